// File: doc/BRIEF.md
# Recirculating Scan Segment Decompressor

The block expands a compressed test stream of variable length into fixed-length scan segments. Every input symbol arrives as a 2-bit binary code, already converted from a three-level pin outside the block. Each symbol is a data bit, an end-of-segment marker, or an idle slot. Data bits shift into a ring register of `SEG_LEN` cells from its tail.

When the marker arrives, the block sends the whole register to the scan chain, head first, for exactly `SEG_LEN` cycles. During that burst each bit leaving the head is also fed back into the tail. The register therefore still holds the segment it has just sent. As a result, a segment equal to the previous one costs a single marker symbol. A segment whose head repeats the previous segment's tail costs only the differing bits plus the marker.

A ready output holds off the tester during the burst. With several chains, a rotating selector routes the scan enable to one chain per segment.

Top module: `ring_reuse_decomp`

## Requirements
- R1: After synchronous reset the outputs are as follows: `ready` is 1, `scanEn` is 0 and `chainEn` is all zeros. The ring holds all zeros, so a marker given right after reset sends `SEG_LEN` zero bits.
- R2: The code values are fixed. 2'b00 is data bit 0, 2'b01 is data bit 1, 2'b10 is the end marker and 2'b11 is idle. An idle code changes nothing.
- R3: The ring keeps the most recent `SEG_LEN` bits. This covers the bits sent last and the data bits accepted since, in arrival order. A data symbol is accepted on a clock edge where `ready` is 1.
- R4: A marker accepted on a clock edge starts the burst from the next cycle. `scanEn` is then 1 for exactly `SEG_LEN` consecutive cycles and `ready` is 0 for that time. `scanOut` presents the oldest retained bit first and the newest last. After the burst, `ready` returns to 1 and `scanEn` to 0.
- R5: After a burst the ring holds exactly the segment just sent. A marker with no data before it therefore repeats that segment.
- R6: Any code presented while `ready` is 0 is ignored.
- R7: While `scanEn` is 1, only the bit of `chainEn` for the selected chain is 1. While `scanEn` is 0, `chainEn` is all zeros.
- R8: The selected chain is 0 after reset. It advances by one after each completed burst and wraps from `CHAINS-1` back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| symCode | input | 2 | Input symbol: 00 bit 0, 01 bit 1, 10 end marker, 11 idle |
| ready | output | 1 | High while a symbol can be accepted |
| scanOut | output | 1 | Serial scan data, valid while scanEn is high |
| scanEn | output | 1 | High during the segment burst |
| chainEn | output | CHAINS | One-hot enable of the selected chain during a burst |

## Verification
A corrupted ring cell shows on `scanOut` in the very next burst. Because every burst recirculates the register, the wrong bit then repeats in every later segment until enough new data pushes it out. A counter that is off by one changes the burst length, and this is visible in `scanEn` and `ready` at the first marker. A selector fault puts the enable on the wrong chain at the end of the first burst, or at the first wrap after `CHAINS` segments.

// File: rtl/ring_reuse_pkg.sv
package ring_reuse_pkg;

  typedef enum logic [1:0] {
    SYM_ZERO = 2'b00,
    SYM_ONE  = 2'b01,
    SYM_END  = 2'b10,
    SYM_IDLE = 2'b11
  } symCode_e;

  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic insBit;    // bit to insert at the ring tail
    logic muxSel;    // 0: insertion bit, 1: recirculate head
    logic shiftEn;   // shift the ring this cycle
    logic cntEn;     // advance the segment counter
    logic chainAdv;  // step the chain selector
  } strobe_t;

endpackage

// File: rtl/sym_decode.sv
module sym_decode
  import ring_reuse_pkg::*;
(
  input  logic [1:0] symCode,
  output logic       symValid,
  output logic       symBit,
  output logic       symEnd
);

  always_comb begin
    symValid = 1'b0;
    symBit   = 1'b0;
    symEnd   = 1'b0;
    case (symCode_e'(symCode))
      SYM_ZERO: begin symValid = 1'b1; symBit = 1'b0; end
      SYM_ONE:  begin symValid = 1'b1; symBit = 1'b1; end
      SYM_END:  symEnd = 1'b1;
      default:  ;
    endcase
  end

endmodule

// File: rtl/decomp_ctrl.sv
module decomp_ctrl
  import ring_reuse_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    symValid,
  input  logic    symBit,
  input  logic    symEnd,
  input  logic    cntLast,
  output strobe_t stb,
  output logic    ready,
  output logic    scanEn
);

  typedef enum logic {ST_LOAD, ST_SHIFT} state_e;
  state_e state;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_LOAD;
    end else begin
      case (state)
        ST_LOAD:  if (symEnd)  state <= ST_SHIFT;
        ST_SHIFT: if (cntLast) state <= ST_LOAD;
        default:  state <= ST_LOAD;
      endcase
    end
  end

  always_comb begin
    stb    = '0;
    ready  = (state == ST_LOAD);
    scanEn = (state == ST_SHIFT);
    if (state == ST_LOAD) begin
      if (symValid) begin
        stb.insBit  = symBit;
        stb.muxSel  = 1'b0;
        stb.shiftEn = 1'b1;
      end
    end else begin
      stb.muxSel   = 1'b1;
      stb.shiftEn  = 1'b1;
      stb.cntEn    = 1'b1;
      stb.chainAdv = cntLast;
    end
  end

  // R4: an accepted marker opens the burst on the next cycle
  p_end_opens_burst_r4: assert property (@(posedge clk) disable iff (rst)
    (ready && symEnd) |=> scanEn);

  // R4: the last counted shift closes the burst
  p_last_closes_burst_r4: assert property (@(posedge clk) disable iff (rst)
    (scanEn && cntLast) |=> (!scanEn && ready));

  // R6: no insertion while the tester is held off
  p_hold_off_r6: assert property (@(posedge clk) disable iff (rst)
    (!ready) |-> stb.muxSel);

endmodule

// File: rtl/ring_datapath.sv
module ring_datapath
  import ring_reuse_pkg::*;
#(
  parameter int SEG_LEN = 10,
  parameter int CHAINS  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           stb,
  input  logic              scanEn,
  output logic              scanOut,
  output logic [CHAINS-1:0] chainEn,
  output logic              cntLast
);

  localparam int CNT_W = $clog2(SEG_LEN + 1);
  localparam int SEL_W = (CHAINS > 1) ? $clog2(CHAINS) : 1;

  logic [SEG_LEN-1:0] ring;
  logic [CNT_W-1:0]   cnt;
  logic [SEL_W-1:0]   sel;
  logic               feedIn;

  // Ring register with its input mux; the head leaves first
  assign feedIn  = stb.muxSel ? ring[SEG_LEN-1] : stb.insBit;
  assign scanOut = ring[SEG_LEN-1];

  always_ff @(posedge clk) begin
    if (rst)              ring <= '0;
    else if (stb.shiftEn) ring <= {ring[SEG_LEN-2:0], feedIn};
  end

  // Segment counter
  assign cntLast = stb.cntEn && (cnt == CNT_W'(SEG_LEN - 1));

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (cntLast)   cnt <= '0;
    else if (stb.cntEn) cnt <= cnt + 1'b1;
  end

  // Chain selector
  always_ff @(posedge clk) begin
    if (rst) begin
      sel <= '0;
    end else if (stb.chainAdv) begin
      if (sel == SEL_W'(CHAINS - 1)) sel <= '0;
      else                           sel <= sel + 1'b1;
    end
  end

  generate
    if (CHAINS == 1) begin : g_single
      assign chainEn = scanEn;
    end else begin : g_multi
      for (genvar c = 0; c < CHAINS; c++) begin : g_chain
        assign chainEn[c] = scanEn && (sel == SEL_W'(c));
      end
    end
  endgenerate

  // R5: the bit leaving the head re-enters at the tail
  p_recirc_r5: assert property (@(posedge clk) disable iff (rst)
    (stb.shiftEn && stb.muxSel) |=> (ring[0] == $past(ring[SEG_LEN-1])));

  // R3: an accepted data bit lands at the tail
  p_insert_r3: assert property (@(posedge clk) disable iff (rst)
    (stb.shiftEn && !stb.muxSel) |=> (ring[0] == $past(stb.insBit)));

  // R4: the counter never passes the segment length
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
    cnt < CNT_W'(SEG_LEN));

  // R7: at most one chain enabled, none outside a burst
  p_chain_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(chainEn));
  p_chain_idle_r7: assert property (@(posedge clk) disable iff (rst)
    (!scanEn) |-> (chainEn == '0));

  // R8: selector wraps after the last chain
  p_sel_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    (stb.chainAdv && sel == SEL_W'(CHAINS - 1)) |=> (sel == '0));

endmodule

// File: rtl/ring_reuse_decomp.sv
module ring_reuse_decomp
  import ring_reuse_pkg::*;
#(
  parameter int SEG_LEN = 10,
  parameter int CHAINS  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        symCode,
  output logic              ready,
  output logic              scanOut,
  output logic              scanEn,
  output logic [CHAINS-1:0] chainEn
);

  logic    symValid;
  logic    symBit;
  logic    symEnd;
  logic    cntLast;
  strobe_t stb;

  sym_decode u_decode (
    .symCode  (symCode),
    .symValid (symValid),
    .symBit   (symBit),
    .symEnd   (symEnd)
  );

  decomp_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .symValid (symValid),
    .symBit   (symBit),
    .symEnd   (symEnd),
    .cntLast  (cntLast),
    .stb      (stb),
    .ready    (ready),
    .scanEn   (scanEn)
  );

  ring_datapath #(
    .SEG_LEN (SEG_LEN),
    .CHAINS  (CHAINS)
  ) u_data (
    .clk     (clk),
    .rst     (rst),
    .stb     (stb),
    .scanEn  (scanEn),
    .scanOut (scanOut),
    .chainEn (chainEn),
    .cntLast (cntLast)
  );

endmodule

// File: tb/ring_reuse_decomp_test.sv
module ring_reuse_decomp_test;

  localparam int L  = 10;
  localparam int NC = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    symCode = 2'b11;
  logic          ready, scanOut, scanEn;
  logic [NC-1:0] chainEn;

  int compared   = 0;
  int mismatched = 0;
  bit finished   = 0;

  logic [L-1:0] model = '0;
  int           chainSel = 0;

  always #4 clk = ~clk;

  ring_reuse_decomp #(.SEG_LEN(L), .CHAINS(NC)) uut (
    .clk     (clk),
    .rst     (rst),
    .symCode (symCode),
    .ready   (ready),
    .scanOut (scanOut),
    .scanEn  (scanEn),
    .chainEn (chainEn)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Present one data bit (R3), optionally preceded by an idle slot (R2)
  task automatic putBit(input bit b, input bit idleFirst);
    if (idleFirst) begin
      @(negedge clk);
      chk("R2 ready around idle", ready, 1);
      symCode = 2'b11;
    end
    @(negedge clk);
    chk("R3 ready before data", ready, 1);
    symCode = {1'b0, b};
    model = {model[L-2:0], b};
  endtask

  // Marker, then check the whole burst (R4, R5, R7, R8); junk tests R6
  task automatic endSeg(input bit junk);
    @(negedge clk);
    symCode = 2'b10;
    @(negedge clk);
    symCode = junk ? 2'b01 : 2'b11;
    for (int i = 0; i < L; i++) begin
      chk("R4 scanEn in burst", scanEn, 1);
      chk("R4 ready low in burst", ready, 0);
      chk("R4 R5 scanOut bit", scanOut, model[L-1-i]);
      chk("R7 chainEn one-hot", chainEn, 32'(1) << chainSel);
      if (i < L - 1) @(negedge clk);
      else symCode = 2'b11;
    end
    @(negedge clk);
    chk("R4 scanEn after burst", scanEn, 0);
    chk("R4 ready after burst", ready, 1);
    chk("R7 chainEn idle", chainEn, 0);
    chainSel = (chainSel + 1) % NC;   // R8
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 ready at reset", ready, 1);
    chk("R1 scanEn at reset", scanEn, 0);
    chk("R1 chainEn at reset", chainEn, 0);
    // R1: marker straight after reset sends zeros on chain 0
    endSeg(0);
    // R3/R5/R6/R8: sweep every insertion length 0..L+3
    for (int s = 0; s < 3 * (L + 4); s++) begin
      int k;
      k = s % (L + 4);
      for (int j = 0; j < k; j++)
        putBit(((s * 7 + j * 3) % 5) < 2, ((s + j) % 3) == 0);
      endSeg(s % 2 == 1);
      if (s % 5 == 0) endSeg(0);   // R5: marker alone repeats
    end
    // R2: a long idle run leaves the ring unchanged
    repeat (7) begin
      @(negedge clk);
      symCode = 2'b11;
    end
    endSeg(0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule